// File: doc/BRIEF.md
# Tagged Conversion Result Queue with Interrupt Unit

This block sits behind a conversion sequencer. Each time the sequencer delivers a 12-bit sample, it also delivers the 4-bit number of the step that produced it. The block stores the pair in a first-in first-out queue. Software reaches the block through a small word-addressed register port. From there it can read how many words are waiting, program a fill threshold and pop words one at a time. Every popped word carries both the sample and the step number, so software can tell which step each result came from.

An interrupt unit collects four events: the queue reaching its threshold, a result lost because the queue was full, a read from the empty queue, and an end-of-sequence pulse from the sequencer. Each event latches a sticky bit in a raw status register. A masked view of that status is formed with an enable mask, which software changes by writing ones to a set register and to a separate clear register. Writing ones to the masked view clears the raw bits. The single interrupt line is the OR of the masked bits. When an event arrives in the same cycle that software clears its bit, the event wins.

Top module: `convq_top`

## Requirements
- R1: After reset the queue is empty, the occupancy reads 0, the threshold reads 0, raw and masked status read 0, the enable mask reads 0 and `irq` is low.
- R2: A popped word holds the sample in bits 11:0 and the step tag in bits 19:16, and every other bit is zero. Words leave in the order they arrived.
- R3: The occupancy register (address 4) reports the number of stored words in bits 6:0, from 0 to 64. Each read of the data register (address 6) removes one word.
- R4: A result offered while 64 words are stored, with no pop in the same cycle, is dropped. The occupancy stays at 64 and status bit 3 (overrun) is set.
- R5: A read of the data register while the queue is empty returns 0, leaves the occupancy at 0 and sets status bit 4 (underflow).
- R6: Status bit 2 (threshold) is set in every cycle in which the threshold register (address 5, 7 bits) is nonzero and the occupancy is at or above it. It is never set while the threshold is 0.
- R7: A one-cycle pulse on `seq_done` sets status bit 1 (end of sequence).
- R8: Raw status (address 0) shows latched events whatever the enable mask holds. Masked status (address 1) reads raw AND enable. Writing ones to address 1 clears the matching raw bits, and status bits otherwise stay set.
- R9: Writing ones to address 2 sets enable bits and writing ones to address 3 clears them. Both addresses read back the mask. Only bits 1 to 4 exist, so bits 0 and 5 to 31 of status and mask always read 0.
- R10: `irq` is high exactly when some status bit is set and enabled.
- R11: When an event sets a status bit in the same cycle that a write to address 1 clears it, the bit stays set.
- R12: Read data appears on `reg_rdata` in the cycle after the read strobe. Writes to addresses 0, 4 and 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Conversion result offered this cycle |
| res_sample | input | 12 | Converted sample value |
| res_tag | input | 4 | Number of the step that produced the sample |
| seq_done | input | 1 | End-of-sequence pulse from the sequencer |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the strobe |
| irq | output | 1 | Interrupt request |

## Verification
Two things can happen in the same cycle: a hardware event setting a status bit, and a software write-one-to-clear to that same bit. The bench provokes this for overrun by offering a result to a full queue during the clear write. It does the same for end of sequence by pulsing `seq_done` during the clear write. It then reads raw status and expects the bit still set. A plain clear with no event must leave the bit at zero. The threshold sweep also shows level-style re-assertion: after a clear, the bit comes back whenever occupancy is still at or above the threshold.

// File: rtl/convq_pkg.sv
package convq_pkg;

    localparam int SAMPLE_W  = 12;
    localparam int TAG_W     = 4;
    localparam int TAG_LSB   = 16;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 3;
    localparam int IRQ_W     = 8;

    // status / enable bit positions
    localparam int IRQ_EOS = 1;
    localparam int IRQ_THR = 2;
    localparam int IRQ_OVR = 3;
    localparam int IRQ_UDF = 4;
    localparam logic [IRQ_W-1:0] IRQ_IMPL = 8'b0001_1110;

    typedef enum logic [ADDR_W-1:0] {
        RA_RAW    = 3'd0,
        RA_MASKED = 3'd1,
        RA_ENSET  = 3'd2,
        RA_ENCLR  = 3'd3,
        RA_COUNT  = 3'd4,
        RA_THRESH = 3'd5,
        RA_DATA   = 3'd6,
        RA_NONE   = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [TAG_W-1:0]    tag;
        logic [SAMPLE_W-1:0] sample;
    } entry_t;

    function automatic logic [WORD_W-1:0] pack_word(entry_t e);
        logic [WORD_W-1:0] w;
        w = '0;
        w[SAMPLE_W-1:0]          = e.sample;
        w[TAG_LSB +: TAG_W]      = e.tag;
        return w;
    endfunction

endpackage

// File: rtl/convq_store.sv
module convq_store
    import convq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  entry_t           push_entry,
    input  logic             pop,
    output entry_t           head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full,
    output logic             ovr_evt,
    output logic             udf_evt
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    entry_t             mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;
    logic               do_push;
    logic               do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign ovr_evt = push && !do_push;
    assign udf_evt = pop && empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT); // R3

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == FULL_CNT)); // R4

    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (count == '0)); // R5

endmodule

// File: rtl/convq_irq.sv
module convq_irq
    import convq_pkg::*;
#(
    parameter int               NBITS = IRQ_W,
    parameter logic [NBITS-1:0] IMPL  = IRQ_IMPL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBITS-1:0] evt,
    input  logic [NBITS-1:0] clr_bits,
    input  logic [NBITS-1:0] en_set,
    input  logic [NBITS-1:0] en_clr,
    output logic [NBITS-1:0] raw,
    output logic [NBITS-1:0] enable,
    output logic             irq
);
    genvar i;
    generate
        for (i = 0; i < NBITS; i++) begin : g_bit
            if (IMPL[i]) begin : g_impl
                always_ff @(posedge clk) begin
                    if (rst) begin
                        raw[i]    <= 1'b0;
                        enable[i] <= 1'b0;
                    end else begin
                        // an event in the clearing cycle keeps the bit
                        raw[i]    <= evt[i] | (raw[i] & ~clr_bits[i]);
                        enable[i] <= (enable[i] | en_set[i]) & ~en_clr[i];
                    end
                end
            end else begin : g_rsvd
                assign raw[i]    = 1'b0;
                assign enable[i] = 1'b0;
            end
        end
    endgenerate

    assign irq = |(raw & enable);

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((($past(raw) & ~$past(clr_bits)) & ~raw)) == '0)); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        |(evt & IMPL) |=> ((raw & $past(evt & IMPL)) == $past(evt & IMPL))); // R11

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((raw | enable) & ~IMPL) == '0); // R9

endmodule

// File: rtl/convq_top.sv
module convq_top
    import convq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                res_valid,
    input  logic [SAMPLE_W-1:0] res_sample,
    input  logic [TAG_W-1:0]    res_tag,
    input  logic                seq_done,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic                irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    reg_addr_e          addr;
    entry_t             in_entry;
    entry_t             head;
    logic [CNT_W-1:0]   count;
    logic [CNT_W-1:0]   thresh;
    logic               empty;
    logic               full;
    logic               ovr_evt;
    logic               udf_evt;
    logic               pop;
    logic               thr_hit;
    logic [IRQ_W-1:0]   evt;
    logic [IRQ_W-1:0]   clr_bits;
    logic [IRQ_W-1:0]   en_set;
    logic [IRQ_W-1:0]   en_clr;
    logic [IRQ_W-1:0]   raw;
    logic [IRQ_W-1:0]   enable;
    logic [WORD_W-1:0]  rd_mux;

    assign addr            = reg_addr_e'(reg_addr);
    assign in_entry.tag    = res_tag;
    assign in_entry.sample = res_sample;
    assign pop             = reg_rd && (addr == RA_DATA);

    convq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push       (res_valid),
        .push_entry (in_entry),
        .pop        (pop),
        .head       (head),
        .count      (count),
        .empty      (empty),
        .full       (full),
        .ovr_evt    (ovr_evt),
        .udf_evt    (udf_evt)
    );

    assign thr_hit = (thresh != '0) && (count >= thresh);

    always_comb begin
        evt          = '0;
        evt[IRQ_EOS] = seq_done;
        evt[IRQ_THR] = thr_hit;
        evt[IRQ_OVR] = ovr_evt;
        evt[IRQ_UDF] = udf_evt;
    end

    assign clr_bits = (reg_wr && addr == RA_MASKED) ? reg_wdata[IRQ_W-1:0] : '0;
    assign en_set   = (reg_wr && addr == RA_ENSET)  ? reg_wdata[IRQ_W-1:0] : '0;
    assign en_clr   = (reg_wr && addr == RA_ENCLR)  ? reg_wdata[IRQ_W-1:0] : '0;

    convq_irq #(.NBITS(IRQ_W), .IMPL(IRQ_IMPL)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .clr_bits (clr_bits),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .raw      (raw),
        .enable   (enable),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            thresh <= '0;
        end else if (reg_wr && addr == RA_THRESH) begin
            thresh <= reg_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        case (addr)
            RA_RAW:    rd_mux = WORD_W'(raw);
            RA_MASKED: rd_mux = WORD_W'(raw & enable);
            RA_ENSET,
            RA_ENCLR:  rd_mux = WORD_W'(enable);
            RA_COUNT:  rd_mux = WORD_W'(count);
            RA_THRESH: rd_mux = WORD_W'(thresh);
            RA_DATA:   rd_mux = empty ? '0 : pack_word(head);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (pop && empty) |=> (reg_rdata == '0)); // R5

    AST_EOS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> raw[IRQ_EOS]); // R7

    AST_THR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        thr_hit |=> raw[IRQ_THR]); // R6

    AST_DATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(pop) |-> (reg_rdata[WORD_W-1:TAG_LSB+TAG_W] == '0)); // R2

endmodule

// File: tb/convq_top_tb_top.sv
module convq_top_tb_top;
    import convq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        res_valid = 1'b0;
    logic [11:0] res_sample = '0;
    logic [3:0]  res_tag = '0;
    logic        seq_done = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    convq_top dut_i (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res_sample(res_sample),
        .res_tag(res_tag), .seq_done(seq_done), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_rd(int a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 3'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic push_one(logic [3:0] t, logic [11:0] s);
        @(negedge clk);
        res_valid = 1'b1; res_tag = t; res_sample = s;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    function automatic logic [11:0] smp(int i);
        return 12'((i * 37 + 5) & 12'hFFF);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        do_rd(0, d); check("R1 raw", d, 0);
        do_rd(1, d); check("R1 masked", d, 0);
        do_rd(2, d); check("R1 enable", d, 0);
        do_rd(4, d); check("R1 count", d, 0);
        do_rd(5, d); check("R1 thresh", d, 0);
        check("R1 irq", 32'(irq), 0);

        // R9 enable set/clear and reserved bits
        do_wr(2, 32'hFFFF_FFFF);
        do_rd(2, d); check("R9 enset readback", d, 32'h1E);
        do_rd(3, d); check("R9 enclr readback", d, 32'h1E);
        do_wr(3, 32'h06);
        do_rd(2, d); check("R9 partial clear", d, 32'h18);
        do_wr(3, 32'hFF);
        do_rd(3, d); check("R9 all clear", d, 0);

        // R3 / R4 fill to capacity then overrun
        for (int i = 0; i < 64; i++) push_one(4'(i % 16), smp(i));
        do_rd(4, d); check("R3 count full", d, 64);
        do_rd(0, d); check("R4 no overrun before", d, 0);
        push_one(4'hF, 12'hABC);
        do_rd(4, d); check("R4 count stays", d, 64);
        do_rd(0, d); check("R4 overrun bit3", d, 32'h08);
        check("R10 irq low when masked off", 32'(irq), 0);

        // R12 writes to read-only addresses
        do_wr(0, 32'h0);
        do_wr(4, 32'h0);
        do_wr(6, 32'h0);
        do_rd(4, d); check("R12 count untouched", d, 64);
        do_rd(0, d); check("R12 raw untouched", d, 32'h08);

        // R8 / R10 masking
        do_wr(2, 32'h08);
        @(negedge clk);
        check("R10 irq high", 32'(irq), 1);
        do_rd(1, d); check("R8 masked view", d, 32'h08);

        // R11 overrun in same cycle as clear
        @(negedge clk);
        res_valid = 1'b1; res_tag = 4'h1; res_sample = 12'h111;
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h08;
        @(negedge clk);
        res_valid = 1'b0; reg_wr = 1'b0;
        do_rd(0, d); check("R11 overrun set wins", d, 32'h08);
        do_wr(1, 32'h08);
        do_rd(0, d); check("R8 w1c clears", d, 0);
        check("R10 irq low after clear", 32'(irq), 0);

        // R2 / R3 drain and verify order and format
        for (int i = 0; i < 64; i++) begin
            do_rd(6, d);
            check("R2 data word", d, (32'(i % 16) << 16) | 32'(smp(i)));
            if (i == 31) begin
                do_rd(4, d); check("R3 count after 32 pops", d, 32);
            end
        end
        do_rd(4, d); check("R3 count empty", d, 0);

        // R5 underflow
        do_rd(6, d); check("R5 empty read zero", d, 0);
        do_rd(4, d); check("R5 count stays zero", d, 0);
        do_rd(0, d); check("R5 underflow bit4", d, 32'h10);

        // R7 end of sequence, R11 with clear
        @(negedge clk); seq_done = 1'b1;
        @(negedge clk); seq_done = 1'b0;
        do_rd(0, d); check("R7 eos bit1", d, 32'h12);
        @(negedge clk);
        seq_done = 1'b1; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h12;
        @(negedge clk);
        seq_done = 1'b0; reg_wr = 1'b0;
        do_rd(0, d); check("R11 eos set wins, udf cleared", d, 32'h02);
        do_wr(1, 32'hFF);
        do_rd(0, d); check("R8 clear all", d, 0);

        // R6 threshold sweep
        for (int t = 0; t <= 6; t++) begin
            do_wr(5, 32'(t));
            do_rd(5, d); check("R6 thresh readback", d, 32'(t));
            for (int n = 0; n <= 6; n++) begin
                do_wr(1, 32'h04);
                do_rd(0, d);
                check($sformatf("R6 thr=%0d cnt=%0d", t, n), d & 32'h04,
                      ((t != 0) && (n >= t)) ? 32'h04 : 32'h0);
                push_one(4'(n), smp(n + 100));
            end
            for (int n = 0; n <= 6; n++) begin
                do_rd(6, d);
                check("R2 sweep data", d, (32'(n) << 16) | 32'(smp(n + 100)));
            end
            do_wr(5, 32'h0);
            do_wr(1, 32'hFF);
        end
        do_rd(0, d); check("R6 final clear", d, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule